// File: doc/BRIEF.md
# ROM Patch Fetch Redirect Unit

This unit sits next to the program counter of an 8-bit processor and lets software replace faulty instructions in mask ROM without changing the ROM itself. Software programs up to two 16-bit patch addresses, one byte at a time, through a small register window at a fixed place in the address space. It then turns on each patch channel with its own enable bit.

On every opcode fetch the unit compares the fetch address with each enabled patch address. When an address matches, the unit raises a one-cycle redirect strobe in the same cycle as the fetch. In that cycle it swaps the fetch address for the base of that channel's 32-byte patch area in RAM. The processor loads its program counter from the substituted address and carries on from there. Channel 1's area starts at 0x02C0 and channel 2's area starts at 0x02E0. The two areas are adjacent, so patch code can run from the first area into the second without a jump. Code that executes inside either area is never compared, so a patch cannot redirect itself.

Top module: `patch_redirect`

## Requirements
- R1: After reset, every register reads 0 and no fetch is redirected.
- R2: The channel 1 patch address is held as a high byte at 0x0242 and a low byte at 0x0243. The channel 2 patch address is held as a high byte at 0x0244 and a low byte at 0x0245. A write takes effect at the clock edge, and a read (combinational on reg_addr) returns the stored byte.
- R3: The enable register is at 0x0246. Bit 0 enables channel 1 and bit 1 enables channel 2 (1 = on). Writes to bits 7..2 are ignored, and those bits read as 0.
- R4: An opcode fetch (fetch_opcode=1) whose address equals the enabled channel 1 patch address drives redirect=1 and fetch_addr_out=0x02C0 in the same cycle.
- R5: An opcode fetch that matches the enabled channel 2 patch address, and not channel 1, drives redirect=1 and fetch_addr_out=0x02E0 in the same cycle.
- R6: An operand fetch (fetch_opcode=0) never redirects, whatever the address.
- R7: A disabled channel never redirects, even when its address matches.
- R8: If both enabled channels hold the matching address, channel 1 wins and fetch_addr_out=0x02C0.
- R9: A fetch address in the range 0x02C0..0x02FF never redirects, even when it is programmed and enabled.
- R10: Whenever redirect=0, fetch_addr_out equals fetch_addr.
- R11: Reads of unmapped register addresses return 0, and writes to them change no mapped register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 16 | Register access address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 8 | Register read data (combinational) |
| fetch_addr | input | 16 | Processor fetch address |
| fetch_opcode | input | 1 | High when the fetch is the first byte of an instruction |
| redirect | output | 1 | One-cycle strobe: the fetch is redirected |
| fetch_addr_out | output | 16 | Fetch address after substitution |

## Verification
The hardest case to reach from the ports is several conditions meeting in one fetch. Both channels must be enabled and hold the same address, or a programmed address must lie inside a patch area. Random addresses would almost never land on one. Directed steps therefore program identical addresses into both channels, and program 0x02D0 and 0x02FF as patch addresses. The random phase then biases about two thirds of its fetches onto the currently programmed addresses. It also writes random bytes into the register window, including the reserved enable bits and its unmapped neighbours, so that priority, masking and the patch-area guard are exercised together.

// File: rtl/patch_pkg.sv
package patch_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;

  // register address of a channel's high byte; the low byte follows it
  function automatic addr_t hi_reg(addr_t reg_base, int unsigned ch);
    return addr_t'(32'(reg_base) + 2 * ch);
  endfunction

  function automatic addr_t lo_reg(addr_t reg_base, int unsigned ch);
    return addr_t'(32'(reg_base) + 2 * ch + 1);
  endfunction

  // enable register sits right after the last address pair
  function automatic addr_t en_reg(addr_t reg_base, int unsigned nch);
    return addr_t'(32'(reg_base) + 2 * nch);
  endfunction

  // start of a channel's RAM patch area
  function automatic addr_t area_base(addr_t win_base, int unsigned bytes, int unsigned ch);
    return addr_t'(32'(win_base) + bytes * ch);
  endfunction

  // true when an address lies anywhere inside the joined patch areas
  function automatic logic in_patch_area(addr_t a, addr_t win_base, int unsigned bytes,
                                         int unsigned nch);
    return (32'(a) >= 32'(win_base)) && (32'(a) < 32'(win_base) + bytes * nch);
  endfunction
endpackage

// File: rtl/patch_regs.sv
module patch_regs
  import patch_pkg::*;
#(
  parameter int unsigned NUM_CH   = 2,
  parameter addr_t       REG_BASE = 16'h0242
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  addr_t                 reg_addr,
  input  byte_t                 reg_wdata,
  input  logic                  reg_we,
  output byte_t                 reg_rdata,
  output addr_t [NUM_CH-1:0]    patch_addr,
  output logic  [NUM_CH-1:0]    enable
);
  localparam addr_t EN_ADDR = en_reg(REG_BASE, NUM_CH);

  byte_t [NUM_CH-1:0] hi_q;
  byte_t [NUM_CH-1:0] lo_q;
  logic  [NUM_CH-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
      en_q <= '0;
    end else if (reg_we) begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (reg_addr == hi_reg(REG_BASE, i)) hi_q[i] <= reg_wdata;
        if (reg_addr == lo_reg(REG_BASE, i)) lo_q[i] <= reg_wdata;
      end
      // reserved upper bits are simply not stored
      if (reg_addr == EN_ADDR) en_q <= reg_wdata[NUM_CH-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (reg_addr == hi_reg(REG_BASE, i)) reg_rdata = hi_q[i];
      if (reg_addr == lo_reg(REG_BASE, i)) reg_rdata = lo_q[i];
    end
    if (reg_addr == EN_ADDR) reg_rdata = byte_t'(en_q);
  end

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_out
      assign patch_addr[g] = {hi_q[g], lo_q[g]};

      AST_HI_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == hi_reg(REG_BASE, g)) |=> (patch_addr[g][15:8] == $past(reg_wdata))); // R2
      AST_LO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == lo_reg(REG_BASE, g)) |=> (patch_addr[g][7:0] == $past(reg_wdata))); // R2
    end
  endgenerate

  assign enable = en_q;

  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == EN_ADDR) |=> (enable == $past(reg_wdata[NUM_CH-1:0]))); // R3
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == EN_ADDR) |=> $stable(enable)); // R11
endmodule

// File: rtl/patch_cmp.sv
module patch_cmp
  import patch_pkg::*;
(
  input  addr_t fetch_addr,
  input  logic  fetch_opcode,
  input  logic  in_area,
  input  logic  enable,
  input  addr_t patch_addr,
  output logic  hit
);
  // a channel fires only on an opcode byte outside the patch areas
  assign hit = enable && fetch_opcode && !in_area && (fetch_addr == patch_addr);
endmodule

// File: rtl/patch_arb.sv
module patch_arb #(
  parameter int unsigned NUM_CH = 2
) (
  input  logic [NUM_CH-1:0] hit,
  output logic [NUM_CH-1:0] grant
);
  logic taken;

  // lowest channel number wins
  always_comb begin
    grant = '0;
    taken = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (hit[i] && !taken) begin
        grant[i] = 1'b1;
        taken    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/patch_redirect.sv
module patch_redirect
  import patch_pkg::*;
#(
  parameter int unsigned NUM_CH    = 2,
  parameter addr_t       REG_BASE  = 16'h0242,
  parameter addr_t       WIN_BASE  = 16'h02C0,
  parameter int unsigned WIN_BYTES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] reg_addr,
  input  logic [7:0]  reg_wdata,
  input  logic        reg_we,
  output logic [7:0]  reg_rdata,
  input  logic [15:0] fetch_addr,
  input  logic        fetch_opcode,
  output logic        redirect,
  output logic [15:0] fetch_addr_out
);
  addr_t [NUM_CH-1:0] patch_addr;
  logic  [NUM_CH-1:0] enable;
  logic  [NUM_CH-1:0] hit;
  logic  [NUM_CH-1:0] grant;
  logic               in_area;

  patch_regs #(.NUM_CH(NUM_CH), .REG_BASE(REG_BASE)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_we     (reg_we),
    .reg_rdata  (reg_rdata),
    .patch_addr (patch_addr),
    .enable     (enable)
  );

  assign in_area = in_patch_area(fetch_addr, WIN_BASE, WIN_BYTES, NUM_CH);

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_cmp
      patch_cmp u_cmp (
        .fetch_addr   (fetch_addr),
        .fetch_opcode (fetch_opcode),
        .in_area      (in_area),
        .enable       (enable[g]),
        .patch_addr   (patch_addr[g]),
        .hit          (hit[g])
      );
    end
  endgenerate

  patch_arb #(.NUM_CH(NUM_CH)) u_arb (
    .hit   (hit),
    .grant (grant)
  );

  always_comb begin
    fetch_addr_out = fetch_addr;
    for (int i = 0; i < NUM_CH; i++) begin
      if (grant[i]) fetch_addr_out = area_base(WIN_BASE, WIN_BYTES, i);
    end
  end

  assign redirect = |grant;

  AST_REDIRECT_ON_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> fetch_opcode); // R6
  AST_NO_SELF_PATCH: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> ((fetch_addr < WIN_BASE) || (32'(fetch_addr) >= 32'(WIN_BASE) + WIN_BYTES * NUM_CH))); // R9
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R8
  AST_GRANT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & ~enable) == '0); // R7
  AST_CH1_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    hit[0] |-> (redirect && fetch_addr_out == WIN_BASE)); // R8
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    !redirect |-> (fetch_addr_out == fetch_addr)); // R10
  AST_TARGET_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> in_patch_area(fetch_addr_out, WIN_BASE, WIN_BYTES, NUM_CH)); // R4
endmodule

// File: tb/patch_redirect_test.sv
module patch_redirect_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_rdata;
  logic [15:0] fetch_addr = '0;
  logic        fetch_opcode = 1'b0;
  logic        redirect;
  logic [15:0] fetch_addr_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] m_hi [2];
  logic [7:0] m_lo [2];
  logic [1:0] m_en;

  always #2 clk = ~clk;

  patch_redirect uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .fetch_addr(fetch_addr),
    .fetch_opcode(fetch_opcode), .redirect(redirect), .fetch_addr_out(fetch_addr_out)
  );

  function automatic logic [7:0] exp_read(logic [15:0] a);
    case (a)
      16'h0242: return m_hi[0];
      16'h0243: return m_lo[0];
      16'h0244: return m_hi[1];
      16'h0245: return m_lo[1];
      16'h0246: return {6'b0, m_en};
      default:  return 8'h00;
    endcase
  endfunction

  function automatic logic [16:0] exp_fetch(logic [15:0] a, logic op);
    logic guard;
    guard = (a >= 16'h02C0) && (a <= 16'h02FF);
    if (op && !guard && m_en[0] && a == {m_hi[0], m_lo[0]}) return {1'b1, 16'h02C0};
    if (op && !guard && m_en[1] && a == {m_hi[1], m_lo[1]}) return {1'b1, 16'h02E0};
    return {1'b0, a};
  endfunction

  task automatic chk(string req, logic [16:0] act, logic [16:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk);
    #1 reg_we = 1'b0;
    case (a)
      16'h0242: m_hi[0] = d;
      16'h0243: m_lo[0] = d;
      16'h0244: m_hi[1] = d;
      16'h0245: m_lo[1] = d;
      16'h0246: m_en = d[1:0];
      default: ;
    endcase
  endtask

  task automatic rd(string req, logic [15:0] a);
    @(negedge clk);
    reg_addr = a;
    #1 chk(req, {9'b0, reg_rdata}, {9'b0, exp_read(a)});
  endtask

  task automatic fetch(string req, logic [15:0] a, logic op);
    @(negedge clk);
    fetch_addr = a; fetch_opcode = op;
    #1 chk(req, {redirect, fetch_addr_out}, exp_fetch(a, op));
  endtask

  task automatic set_ch(int ch, logic [15:0] v);
    wr(16'h0242 + 16'(2 * ch), v[15:8]);
    wr(16'h0243 + 16'(2 * ch), v[7:0]);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 2; i++) begin m_hi[i] = 0; m_lo[i] = 0; end
    m_en = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    for (int a = 16'h0242; a <= 16'h0246; a++) rd("R1", 16'(a));
    fetch("R1", 16'h0000, 1'b1);

    // R2 register map
    set_ch(0, 16'h1234);
    set_ch(1, 16'h8001);
    rd("R2", 16'h0242); rd("R2", 16'h0243); rd("R2", 16'h0244); rd("R2", 16'h0245);

    // R3 reserved bits ignored
    wr(16'h0246, 8'hFF);
    rd("R3", 16'h0246);

    fetch("R4", 16'h1234, 1'b1);
    fetch("R5", 16'h8001, 1'b1);
    fetch("R6", 16'h1234, 1'b0);
    fetch("R10", 16'h5555, 1'b1);

    // R7 channel 1 off
    wr(16'h0246, 8'h02);
    fetch("R7", 16'h1234, 1'b1);
    fetch("R5", 16'h8001, 1'b1);

    // R8 same address on both channels
    set_ch(0, 16'h4444); set_ch(1, 16'h4444);
    wr(16'h0246, 8'h03);
    fetch("R8", 16'h4444, 1'b1);
    wr(16'h0246, 8'h02);
    fetch("R8", 16'h4444, 1'b1);

    // R9 patch areas are never compared
    set_ch(0, 16'h02D0); set_ch(1, 16'h02FF);
    wr(16'h0246, 8'h03);
    fetch("R9", 16'h02D0, 1'b1);
    fetch("R9", 16'h02FF, 1'b1);

    // R11 unmapped neighbours
    wr(16'h0247, 8'hA5); wr(16'h0241, 8'h5A);
    rd("R11", 16'h0247); rd("R11", 16'h0241);
    rd("R11", 16'h0242); rd("R11", 16'h0245); rd("R11", 16'h0246);

    // constrained random mix
    for (int it = 0; it < 600; it++) begin
      int unsigned pick;
      pick = $urandom % 4;
      if (pick == 0) begin
        logic [15:0] a;
        a = 16'h0241 + 16'($urandom % 7);
        wr(a, 8'($urandom));
        rd("R2", a);
      end else begin
        int unsigned sel;
        logic [15:0] a;
        sel = $urandom % 3;
        if (sel == 0) a = {m_hi[0], m_lo[0]};
        else if (sel == 1) a = {m_hi[1], m_lo[1]};
        else a = 16'($urandom);
        if ($urandom % 8 == 0) begin
          a = 16'h02C0 + 16'($urandom % 64);
          set_ch(int'($urandom % 2), a);
        end
        fetch("R4", a, 1'($urandom));
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule